// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Interface

This peripheral sits on a simple 32-bit register bus and drives one SPI target through a serial clock, a data-out line, a data-in line and one active-low select. Software sets the clock rate and the clock mode in a control word and turns on master operation. It then writes a byte to the transmit port. The block shifts that byte out MSB first and, during the same frame, shifts a byte in. Software polls a busy flag and a receive-full flag in the status word, then reads the received byte.

The serial clock comes from two divider stages. The first stage divides the system clock by a small or a large prescale factor, chosen by one control bit (16 or 128 by default). The second stage divides again by 2×(N+1), where N is a 5-bit control field. All four combinations of clock polarity and clock phase are supported. Every frame is exactly 8 bits.

Top module: `spim_top`

## Requirements
- R1: After reset, cs_n is 1 and sclk is 0. The status, control, mode-enable and receive-port reads all return 0.
- R2: During a frame, sclk toggles every P×(N+1) system clocks. N is control bits [4:0]. P is the large prescale when control bit 5 is 1 and the small prescale when it is 0.
- R3: While no frame is running, sclk holds the polarity given by control bit 6.
- R4: A frame has 16 sclk edges and moves data MSB first in both directions. With control bit 7 at 0, data is sampled on the leading edge (the edge away from idle level) and changed on the trailing edge. With control bit 7 at 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: cs_n goes low in the cycle after the write that starts a frame. It stays low through edge 15 and returns high in the same cycle as edge 16.
- R6: Status bit 0 reads 1 from the starting write until the frame's last edge.
- R7: After a frame, status bit 2 becomes 1. The received byte reads in bits [7:0] of offset 0x10, with zeros above.
- R8: A read of offset 0x10 clears status bit 2.
- R9: A write to the status word (offset 0x04) with bit 2 at 0 clears status bit 2.
- R10: Bit 0 of offset 0x08 enables master operation and reads back. A write to the transmit port (offset 0x0C) while it is 0 is ignored: no frame starts, cs_n stays high and sclk does not move.
- R11: While a frame is running, writes to the transmit port and to the control word are ignored. The running frame and the stored control value are not affected.
- R12: The control word (offset 0x00) reads back bits [7:0] as written. Offset 0x14 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read (needed to clear the receive flag) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| cs_n | output | 1 | Active-low target select |

## Verification
The bench sweeps every polarity/phase combination against both prescale choices and several divider values. A behavioural target model checks both data directions on the edges the mode calls for. A block that sampled on the wrong edge, or shifted before the first bit in phase-1 mode, would return a byte rotated or shifted by one. The bench measures every half-period of sclk, so a divider off by one in either stage shows up directly. It also checks that the select line releases on the sixteenth edge and not one clock early or late, and that sclk returns to its idle level. Writes while disabled and writes while busy are checked at the pins and through read-back: a design that honoured them would toggle sclk, restart the frame or corrupt the stored control word.

// File: rtl/spim_pkg.sv
// Package: shared constants and the control word layout for the SPI master.
// Assumes byte offsets on the register bus; only the low bits are decoded.
package spim_pkg;
    localparam int FRAME_BITS = 8;
    localparam int DIV_W      = 5;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_MODE  = 8'h08;
    localparam logic [7:0] OFS_TX    = 8'h0C;
    localparam logic [7:0] OFS_RX    = 8'h10;
    localparam logic [7:0] OFS_CTRL2 = 8'h14;

    localparam int ST_BUSY   = 0;
    localparam int ST_RXFULL = 2;

    // Control word, bit 7 down to bit 0.
    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             pre_hi;
        logic [DIV_W-1:0] div;
    } ctrl_t;
endpackage

// File: rtl/spim_clkgen.sv
// Module: two-stage serial clock divider.
// Emits one edge_tick every PRE*(div_n+1) cycles while run is high.
// Assumes both prescale factors are at least 2 and div_n stays constant during a run.
module spim_clkgen #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int DIV_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_hi,
    input  logic [DIV_W-1:0] div_n,
    output logic             edge_tick
);
    localparam int PRE_MAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
    localparam int PW      = $clog2(PRE_MAX);

    logic [PW-1:0]    pre_cnt;
    logic [PW-1:0]    pre_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_wrap;

    // Select the prescale terminal count and form the tick.
    always_comb begin
        pre_lim   = pre_hi ? PW'(PRE_HI - 1) : PW'(PRE_LO - 1);
        pre_wrap  = (pre_cnt == pre_lim);
        edge_tick = pre_wrap && (div_cnt == div_n);
    end

    // Advance the prescaler, then the divider on each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= edge_tick ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (div_cnt <= div_n));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0));
endmodule

// File: rtl/spim_shifter.sv
// Module: frame engine. It owns select, serial clock level and both shift registers.
// Assumes start arrives only while idle and mode inputs stay constant during a frame.
module spim_shifter
    import spim_pkg::*;
#(
    parameter int BITS = FRAME_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            edge_tick,
    input  logic            miso,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    output logic            cs_n,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int EDGES = 2 * BITS;
    localparam int CW    = $clog2(EDGES);

    logic [CW-1:0]   edge_cnt;
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] rx_sh;
    logic [BITS-1:0] rx_next;
    logic            busy_q, sclk_q, cs_n_q, done_q;
    logic            leading, sample_now, shift_ok, last_edge;

    // Classify the coming edge for this mode.
    always_comb begin
        leading    = ~edge_cnt[0];
        sample_now = cpha ? ~leading : leading;
        shift_ok   = !(cpha && (edge_cnt == '0));
        last_edge  = (edge_cnt == CW'(EDGES - 1));
        rx_next    = {rx_sh[BITS-2:0], miso};
    end

    // Run the frame: load on start, toggle and shift on each tick, finish on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            sclk_q   <= 1'b0;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            edge_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_byte  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                sclk_q <= cpol;
                if (start) begin
                    busy_q   <= 1'b1;
                    cs_n_q   <= 1'b0;
                    tx_sh    <= tx_byte;
                    rx_sh    <= '0;
                    edge_cnt <= '0;
                end
            end else if (edge_tick) begin
                sclk_q   <= ~sclk_q;
                edge_cnt <= edge_cnt + 1'b1;
                if (sample_now) begin
                    rx_sh <= rx_next;
                end else if (shift_ok) begin
                    tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                end
                if (last_edge) begin
                    busy_q  <= 1'b0;
                    cs_n_q  <= 1'b1;
                    done_q  <= 1'b1;
                    rx_byte <= sample_now ? rx_next : rx_sh;
                end
            end
        end
    end

    assign busy = busy_q;
    assign sclk = sclk_q;
    assign cs_n = cs_n_q;
    assign done = done_q;
    assign mosi = tx_sh[BITS-1];

    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> (sclk_q == $past(cpol)));

    p_tick_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |-> busy_q);

    p_done_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> ($past(edge_tick) && done_q));
endmodule

// File: rtl/spim_regs.sv
// Module: register bank. It decodes the bus, holds the control word, the enable bit,
// the receive byte and its flag, and issues the start pulse.
// Assumes one-cycle strobes and combinational read data.
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic                  bus_re,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic [FRAME_BITS-1:0] rx_byte,
    output ctrl_t                 ctrl,
    output logic                  master_en,
    output logic                  start,
    output logic [FRAME_BITS-1:0] tx_byte
);
    ctrl_t                 ctrl_q;
    logic                  master_q;
    logic                  rxfull_q;
    logic [FRAME_BITS-1:0] rxbuf_q;
    logic hit_ctrl, hit_stat, hit_mode, hit_tx, hit_rx;
    logic clr_full;

    // Decode the offset into one hit line per register.
    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
        hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
        hit_tx   = (bus_addr == ADDR_W'(OFS_TX));
        hit_rx   = (bus_addr == ADDR_W'(OFS_RX));
        start    = bus_we && hit_tx && master_q && !busy;
        clr_full = (bus_re && hit_rx) || (bus_we && hit_stat && !bus_wdata[ST_RXFULL]);
    end

    // Hold the control word and the enable bit; control is frozen during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            master_q <= 1'b0;
        end else begin
            if (bus_we && hit_ctrl && !busy) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
            if (bus_we && hit_mode)          master_q <= bus_wdata[0];
        end
    end

    // Capture the received byte and manage the receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxfull_q <= 1'b0;
            rxbuf_q  <= '0;
        end else if (done) begin
            rxfull_q <= 1'b1;
            rxbuf_q  <= rx_byte;
        end else if (clr_full) begin
            rxfull_q <= 1'b0;
        end
    end

    // Return read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) bus_rdata[7:0] = ctrl_q;
        if (hit_stat) begin
            bus_rdata[ST_BUSY]   = busy;
            bus_rdata[ST_RXFULL] = rxfull_q;
        end
        if (hit_mode) bus_rdata[0] = master_q;
        if (hit_rx)   bus_rdata[FRAME_BITS-1:0] = rxbuf_q;
    end

    assign ctrl      = ctrl_q;
    assign master_en = master_q;
    assign tx_byte   = bus_wdata[FRAME_BITS-1:0];

    p_done_sets_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rxfull_q);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && hit_rx && !done) |=> !rxfull_q);

    p_ctrl_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl_q));
endmodule

// File: rtl/spim_top.sv
// Module: top of the SPI master. It wires the register bank, divider and frame engine.
// Assumes a single target and 8-bit frames; prescale factors are parameters.
module spim_top
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    ctrl_t                 ctrl;
    logic                  master_en, start, busy, done, edge_tick;
    logic [FRAME_BITS-1:0] tx_byte, rx_byte;

    spim_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .rx_byte(rx_byte), .ctrl(ctrl),
        .master_en(master_en), .start(start), .tx_byte(tx_byte)
    );

    spim_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(busy), .pre_hi(ctrl.pre_hi),
        .div_n(ctrl.div), .edge_tick(edge_tick)
    );

    spim_shifter #(.BITS(FRAME_BITS)) u_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .cpol(ctrl.cpol), .cpha(ctrl.cpha), .edge_tick(edge_tick), .miso(miso),
        .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(done),
        .rx_byte(rx_byte)
    );

    p_start_needs_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(master_en));

    p_select_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);
endmodule

// File: tb/spim_top_bench.sv
// Bench: sweeps all clock modes, both prescales and several dividers against a target model.
module spim_top_bench;
    localparam int BP_LO = 2;
    localparam int BP_HI = 4;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_MODE = 5'h08,
                           A_TX = 5'h0C, A_RX = 5'h10, A_CTRL2 = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b0;

    int total = 0;
    int bad = 0;

    // target model state
    logic       m_cpol = 1'b0, m_cpha = 1'b0;
    logic [7:0] m_byte = '0;
    logic [7:0] s_sh = '0, cap = '0;
    logic       sc_prev = 1'b0, cs_prev = 1'b1, in_frame = 1'b0;
    int         en = 0, cyc = 0, last_cyc = 0, min_int = 0, max_int = 0, cs_err = 0;

    always #10 clk = ~clk;

    spim_top #(.ADDR_W(5), .PRE_LO(BP_LO), .PRE_HI(BP_HI)) u_spim_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // Target model and edge monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        logic lead, samp;
        cyc = cyc + 1;
        if (cs_prev && !cs_n) begin
            in_frame = 1'b1; en = 0; cap = '0; s_sh = m_byte; miso = m_byte[7];
            min_int = 1 << 30; max_int = 0; cs_err = 0;
        end else if (in_frame && (sclk != sc_prev)) begin
            en = en + 1;
            if (en > 1) begin
                if (cyc - last_cyc < min_int) min_int = cyc - last_cyc;
                if (cyc - last_cyc > max_int) max_int = cyc - last_cyc;
            end
            last_cyc = cyc;
            lead = (sclk != m_cpol);
            samp = m_cpha ? !lead : lead;
            if (samp) cap = {cap[6:0], mosi};
            else if (!(m_cpha && en == 1)) begin
                s_sh = {s_sh[6:0], 1'b0}; miso = s_sh[7];
            end
            if (en == 16) begin
                in_frame = 1'b0;
                if (!cs_n) cs_err = cs_err + 1;
            end else if (cs_n) cs_err = cs_err + 1;
        end
        sc_prev = sclk;
        cs_prev = cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n;
        n = 0;
        s = 32'h1;
        while (s[0] && n < 5000) begin rd(A_STAT, s); n++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic pol, input logic pha, input logic sel,
                         input logic [4:0] dv, input logic [7:0] tx, input logic [7:0] sb);
        logic [31:0] r;
        logic [7:0]  cw;
        int h;
        cw = {pha, pol, sel, dv};
        h = (sel ? BP_HI : BP_LO) * (int'(dv) + 1);
        wr(A_CTRL, {24'h0, cw});
        m_cpol = pol; m_cpha = pha; m_byte = sb;
        @(negedge clk);
        chk(sclk == pol, "R3 idle level", sclk, pol);
        rd(A_CTRL, r);
        chk(r == {24'h0, cw}, "R12 ctrl readback", r, cw);
        wr(A_TX, {24'hABCDEF, tx});
        chk(cs_n == 1'b0, "R5 select low", cs_n, 0);
        rd(A_STAT, r);
        chk(r[0] == 1'b1, "R6 busy", r[0], 1);
        wait_idle();
        chk(en == 16, "R4 edge count", en, 16);
        chk(cap == tx, "R4 mosi byte", cap, tx);
        chk(min_int == h && max_int == h, "R2 half period", max_int, h);
        chk(min_int == h, "R2 half period min", min_int, h);
        chk(cs_n == 1'b1 && cs_err == 0, "R5 select release", cs_err, 0);
        chk(sclk == pol, "R3 level after frame", sclk, pol);
        rd(A_STAT, r);
        chk(r == 32'h4, "R7 rx full", r, 4);
        rd(A_RX, r);
        chk(r == {24'h0, sb}, "R7 rx byte", r, sb);
        rd(A_STAT, r);
        chk(r == 32'h0, "R8 read clears", r, 0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [4:0]  dvs [4] = '{5'd0, 5'd1, 5'd2, 5'd5};
        logic        s0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        rd(A_STAT, r);  chk(r == 0, "R1 status", r, 0);
        rd(A_CTRL, r);  chk(r == 0, "R1 ctrl", r, 0);
        rd(A_MODE, r);  chk(r == 0, "R1 mode", r, 0);
        rd(A_RX, r);    chk(r == 0, "R1 rx", r, 0);
        rd(A_CTRL2, r); chk(r == 0, "R12 spare offset", r, 0);

        // R10: transmit write with master disabled
        wr(A_CTRL, 32'h40);
        wr(A_TX, 32'h5A);
        s0 = sclk; c0 = cs_n;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk != s0 || cs_n != c0) begin
                chk(1'b0, "R10 pins moved", i, -1);
                break;
            end
        end
        chk(cs_n == 1'b1 && sclk == 1'b1, "R10 pins idle", cs_n, 1);
        rd(A_STAT, r); chk(r == 0, "R10 no frame", r, 0);

        wr(A_MODE, 32'h1);
        rd(A_MODE, r); chk(r == 1, "R10 mode readback", r, 1);

        // Main sweep: all modes, both prescales, several dividers.
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++)
                for (int d = 0; d < 4; d++)
                    frame(m[1], m[0], p[0], dvs[d],
                          8'(8'hA5 ^ (m * 37 + p * 11 + d * 71)),
                          8'(8'h3C + m * 53 + p * 29 + d * 17));

        // R9: clear the receive flag by writing the status word.
        frame(1'b0, 1'b0, 1'b0, 5'd0, 8'h81, 8'h7E);
        wr(A_TX, 32'h18);
        wait_idle();
        rd(A_STAT, r); chk(r == 4, "R9 flag set", r, 4);
        wr(A_STAT, 32'h0);
        rd(A_STAT, r); chk(r == 0, "R9 write clears", r, 0);
        chk(cap == 8'h18, "R4 back to back", cap, 8'h18);

        // R11: writes while busy are ignored.
        wr(A_CTRL, 32'h01);
        m_cpol = 1'b0; m_cpha = 1'b0; m_byte = 8'hC3;
        wr(A_TX, 32'hE7);
        wr(A_TX, 32'h11);
        wr(A_CTRL, 32'hE0);
        wait_idle();
        chk(cap == 8'hE7, "R11 frame kept", cap, 8'hE7);
        chk(en == 16, "R11 single frame", en, 16);
        rd(A_CTRL, r); chk(r == 32'h01, "R11 ctrl kept", r, 1);
        rd(A_RX, r); chk(r == 32'hC3, "R11 rx byte", r, 8'hC3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule